// File: doc/BRIEF.md
# Switch-Monitor Serial Capture Port

This block is the serial side of a multi-input switch monitor. A host lowers chip select to freeze the present switch levels into a status register. It then clocks that snapshot out of a serial data output, most significant bit first. During the same clock cycles it shifts in a new interrupt mask, and the block commits that mask when chip select returns high. Because the output of one device can feed the input of the next, several devices can share one chip select and one serial clock in a chain.

The block runs entirely in a fast system clock. Chip select, serial clock and serial data are brought in through synchronizer chains and reduced to single-cycle edge events. The serial output is presented as a data bit and an enable, so the pad driver can stay outside. Committing a mask of all zeros acts as a software reset: both the status register and the mask end up cleared. The status register, the mask and a one-cycle capture strobe are exported to the interrupt logic.

Top module: `gpi_spi_capture`

## Requirements
- R1: After reset the status register and the mask register are all zeros, the output enable is low and the capture strobe is low.
- R2: A falling chip select copies the switch inputs into the status register and raises the capture strobe for exactly one system clock cycle.
- R3: With chip select low, the first rising serial clock edge loads the shift register from the status register so that its bit NUM_IN-1 appears on the serial output; each later rising edge moves the next lower bit onto the serial output.
- R4: Serial input is sampled on falling serial clock edges, and the word committed at chip select rise holds the last NUM_IN sampled bits with the earliest one at bit NUM_IN-1.
- R5: The mask register changes only in the cycle after a rising chip select; during a frame it keeps its previous value.
- R6: The serial output enable is high while chip select is low and low while chip select is high.
- R7: Serial clock and serial data activity while chip select is high changes neither the status register nor the mask.
- R8: A frame may carry more than NUM_IN clock cycles; after the first NUM_IN output bits the serial output repeats the serial input bits in the order received, delayed by NUM_IN cycles, and the mask takes the last NUM_IN bits.
- R9: Committing an all-zero mask also clears the status register to zero.
- R10: A frame with no falling serial clock edge captures the inputs but leaves the mask unchanged.
- R11: Switch input changes while chip select stays low do not alter the status register or the bits shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select from the host, active low |
| sclk_i | input | 1 | Serial clock from the host, idle low |
| sdin_i | input | 1 | Serial data from the host or the previous device |
| gpi_i | input | NUM_IN | Switch input levels |
| status_o | output | NUM_IN | Input status register |
| mask_o | output | NUM_IN | Interrupt mask register, 1 = bit enabled |
| capture_o | output | 1 | One-cycle strobe when the inputs are captured |
| sdout_o | output | 1 | Serial data output bit |
| sdout_oe_o | output | 1 | Serial output driver enable |

## Verification
The assertions check on every cycle that the mask moves only right after a chip select rise, that the status register moves only on a capture or an all-zero commit, that the strobe is a single cycle following each chip select fall, and that the output enable follows the synchronized chip select. The bit order on the serial output, the alignment of the committed mask in long chained frames, and the fact that activity outside a frame or input changes inside one have no effect can only be shown by the bench's frame scenarios, which compare the serial stream and registers against values worked out from the requirements.

// File: rtl/gpi_spi_pkg.sv
package gpi_spi_pkg;
   // Edge events derived from a synchronized level
   typedef struct packed {
      logic level;
      logic rise;
      logic fall;
   } edge_ev_t;

   localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/gpi_sync.sv
module gpi_sync #(
   parameter int unsigned WIDTH   = 3,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < gpi_spi_pkg::MIN_SYNC_STAGES) begin : g_bad_stages
      $error("gpi_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
         else        chain_q <= {chain_q[STAGES-2:0], d_i[b]};
      end
      assign q_o[b] = chain_q[STAGES-1];
   end
endmodule

// File: rtl/gpi_edge.sv
module gpi_edge #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   lvl_i,
   output gpi_spi_pkg::edge_ev_t  ev_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= lvl_i;
   end

   assign ev_o.level = lvl_i;
   assign ev_o.rise  = lvl_i & ~prev_q;
   assign ev_o.fall  = ~lvl_i & prev_q;
endmodule

// File: rtl/gpi_shift_core.sv
module gpi_shift_core #(
   parameter int unsigned NUM_IN = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  gpi_spi_pkg::edge_ev_t  cs_ev_i,
   input  logic                   sclk_rise_i,
   input  logic                   sclk_fall_i,
   input  logic                   sdin_i,
   input  logic [NUM_IN-1:0]      gpi_i,
   output logic [NUM_IN-1:0]      status_o,
   output logic [NUM_IN-1:0]      mask_o,
   output logic                   capture_o,
   output logic                   sdout_o
);
   localparam int unsigned MSB = NUM_IN - 1;

   logic [NUM_IN-1:0] status_q, mask_q, shreg_q;
   logic              capture_q;
   logic              load_pend_q;   // first rising edge still to come
   logic              held_q;        // bit sampled on last falling edge
   logic              got_bit_q;     // at least one falling edge this frame
   logic              in_frame;
   logic [NUM_IN-1:0] commit_word;

   assign in_frame    = ~cs_ev_i.level & ~cs_ev_i.fall;
   assign commit_word = {shreg_q[MSB-1:0], held_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q    <= '0;
         mask_q      <= '0;
         shreg_q     <= '0;
         capture_q   <= 1'b0;
         load_pend_q <= 1'b0;
         held_q      <= 1'b0;
         got_bit_q   <= 1'b0;
      end else begin
         capture_q <= 1'b0;
         if (cs_ev_i.fall) begin
            status_q    <= gpi_i;
            capture_q   <= 1'b1;
            load_pend_q <= 1'b1;
            got_bit_q   <= 1'b0;
         end else if (cs_ev_i.rise) begin
            if (got_bit_q) begin
               mask_q <= commit_word;
               if (commit_word == '0) status_q <= '0;
            end
            load_pend_q <= 1'b0;
         end else if (in_frame) begin
            if (sclk_rise_i) begin
               if (load_pend_q) begin
                  shreg_q     <= status_q;
                  load_pend_q <= 1'b0;
               end else begin
                  shreg_q <= commit_word;
               end
            end
            if (sclk_fall_i) begin
               held_q    <= sdin_i;
               got_bit_q <= 1'b1;
            end
         end
      end
   end

   assign status_o  = status_q;
   assign mask_o    = mask_q;
   assign capture_o = capture_q;
   assign sdout_o   = shreg_q[MSB];
endmodule

// File: rtl/gpi_spi_capture.sv
module gpi_spi_capture #(
   parameter int unsigned NUM_IN      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_i,
   input  logic              sclk_i,
   input  logic              sdin_i,
   input  logic [NUM_IN-1:0] gpi_i,
   output logic [NUM_IN-1:0] status_o,
   output logic [NUM_IN-1:0] mask_o,
   output logic              capture_o,
   output logic              sdout_o,
   output logic              sdout_oe_o
);
   import gpi_spi_pkg::*;

   localparam int unsigned SER_W = 3;
   localparam logic [SER_W-1:0] SER_IDLE = 3'b100; // cs high, sclk low, sdin low

   if (NUM_IN < 2) begin : g_bad_width
      $error("gpi_spi_capture: NUM_IN must be at least 2");
   end

   logic [SER_W-1:0] ser_raw, ser_s;
   edge_ev_t         cs_ev, sclk_ev;
   logic             cs_fall, cs_rise, cs_low;

   assign ser_raw = {cs_n_i, sclk_i, sdin_i};

   gpi_sync #(.WIDTH(SER_W), .STAGES(SYNC_STAGES), .RST_VAL(SER_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(ser_raw), .q_o(ser_s)
   );

   gpi_edge #(.RST_VAL(1'b1)) u_cs_edge (
      .clk(clk), .rst_n(rst_n), .lvl_i(ser_s[2]), .ev_o(cs_ev)
   );

   gpi_edge #(.RST_VAL(1'b0)) u_sclk_edge (
      .clk(clk), .rst_n(rst_n), .lvl_i(ser_s[1]), .ev_o(sclk_ev)
   );

   gpi_shift_core #(.NUM_IN(NUM_IN)) u_core (
      .clk(clk), .rst_n(rst_n),
      .cs_ev_i(cs_ev),
      .sclk_rise_i(sclk_ev.rise), .sclk_fall_i(sclk_ev.fall),
      .sdin_i(ser_s[0]), .gpi_i(gpi_i),
      .status_o(status_o), .mask_o(mask_o),
      .capture_o(capture_o), .sdout_o(sdout_o)
   );

   assign cs_fall    = cs_ev.fall;
   assign cs_rise    = cs_ev.rise;
   assign cs_low     = ~cs_ev.level;
   assign sdout_oe_o = cs_low;
endmodule

// File: rtl/gpi_spi_capture_chk.sv
module gpi_spi_capture_chk #(
   parameter int unsigned NUM_IN = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_fall,
   input logic              cs_rise,
   input logic [NUM_IN-1:0] status_o,
   input logic [NUM_IN-1:0] mask_o,
   input logic              capture_o,
   input logic              sdout_oe_o
);
   // R1: reset state
   always @(posedge clk)
      if (!rst_n) a_r1_reset_zero: assert (status_o == '0 && mask_o == '0 && !capture_o);

   a_r2_strobe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall |=> capture_o);
   a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      capture_o |=> !capture_o);
   a_r2_status_source: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(status_o) |-> ($past(cs_fall) || ($past(cs_rise) && status_o == '0)));
   a_r5_mask_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mask_o) |-> $past(cs_rise));
   a_r6_oe_on: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall |=> sdout_oe_o);
   a_r6_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise |=> !sdout_oe_o);
   a_r9_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(mask_o) && mask_o == '0) |-> status_o == '0);
endmodule

bind gpi_spi_capture gpi_spi_capture_chk #(.NUM_IN(NUM_IN)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
   .status_o(status_o), .mask_o(mask_o), .capture_o(capture_o),
   .sdout_oe_o(sdout_oe_o)
);

// File: tb/tb_gpi_spi_capture.sv
module tb_gpi_spi_capture;
   localparam int N = 16;
   localparam int PH = 8;   // system clocks per serial clock phase

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
   logic [N-1:0] gpi = '0;
   logic [N-1:0] status, mask;
   logic capture, sdout, sdout_oe;

   int n_vec = 0, n_bad = 0, n_pulse = 0, n_frames = 0;
   logic [N-1:0] exp_q[$];

   always #2 clk = ~clk;   // 250 MHz

   gpi_spi_capture #(.NUM_IN(N)) dut (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdin_i(sdin),
      .gpi_i(gpi), .status_o(status), .mask_o(mask), .capture_o(capture),
      .sdout_o(sdout), .sdout_oe_o(sdout_oe)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Monitor: each capture strobe pops the expected snapshot (R2)
   always @(negedge clk) begin
      if (rst_n && capture) begin
         n_pulse++;
         if (exp_q.size() == 0) chk("R2 unexpected capture", 1, 0);
         else chk("R2 captured status", status, exp_q.pop_front());
      end
   end

   // Driver: one frame of nclk serial cycles
   task automatic frame(input logic [N-1:0] sw, input logic [N-1:0] sw_late,
                        input int nclk, input logic [63:0] din,
                        output logic [63:0] dout);
      logic [N-1:0] mask_before;
      mask_before = mask;
      dout = '0;
      gpi = sw;
      exp_q.push_back(sw);
      n_frames++;
      wclk(2);
      cs_n = 1'b0;
      wclk(PH);
      chk("R6 oe while selected", sdout_oe, 1);
      gpi = sw_late;
      for (int k = 0; k < nclk; k++) begin
         sdin = din[nclk-1-k];
         wclk(2);
         sclk = 1'b1;
         wclk(PH);
         dout[nclk-1-k] = sdout;
         sclk = 1'b0;
         wclk(PH);
      end
      chk("R5 mask held in frame", mask, mask_before);
      chk("R11 status held in frame", status, sw);
      cs_n = 1'b1;
      wclk(PH);
      chk("R6 oe released", sdout_oe, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [63:0] d;
      wclk(3);
      // R1 reset state
      chk("R1 status", status, 0);
      chk("R1 mask", mask, 0);
      chk("R1 oe", sdout_oe, 0);
      chk("R1 capture", capture, 0);
      rst_n = 1'b1;
      wclk(6);
      chk("R1 no capture after reset", n_pulse, 0);

      // R3/R4 basic frame
      frame(16'hA5C3, 16'hA5C3, 16, 64'h1234, d);
      chk("R3 serial out MSB first", d[15:0], 16'hA5C3);
      chk("R4 mask committed", mask, 16'h1234);
      chk("R2 status after frame", status, 16'hA5C3);

      // R11 inputs change while selected
      frame(16'h3C5A, 16'hFFFF, 16, 64'hBEEF, d);
      chk("R11 shifted snapshot", d[15:0], 16'h3C5A);
      chk("R4 second mask", mask, 16'hBEEF);

      // R7 activity while deselected
      for (int k = 0; k < 5; k++) begin
         sdin = k[0];
         sclk = 1'b1; wclk(PH);
         sclk = 1'b0; wclk(PH);
      end
      gpi = 16'h0000;
      wclk(PH);
      chk("R7 mask untouched", mask, 16'hBEEF);
      chk("R7 status untouched", status, 16'h3C5A);
      chk("R6 oe low deselected", sdout_oe, 0);

      // R8 chained frame, 32 clocks
      frame(16'h8001, 16'h8001, 32, {32'h0, 16'hCAFE, 16'h0F0F}, d);
      chk("R8 own word first", d[31:16], 16'h8001);
      chk("R8 pass-through", d[15:0], 16'hCAFE);
      chk("R8 last bits are mask", mask, 16'h0F0F);

      // R10 frame without serial clocks
      frame(16'h1111, 16'h1111, 0, 64'h0, d);
      chk("R10 mask unchanged", mask, 16'h0F0F);
      chk("R10 status captured", status, 16'h1111);

      // R9 all-zero commit
      frame(16'h7777, 16'h7777, 16, 64'h0, d);
      chk("R9 read before clear", d[15:0], 16'h7777);
      chk("R9 mask zero", mask, 16'h0000);
      chk("R9 status cleared", status, 16'h0000);

      // All ones after software reset
      frame(16'hFFFF, 16'hFFFF, 16, 64'hFFFF, d);
      chk("R3 all ones out", d[15:0], 16'hFFFF);
      chk("R4 all ones mask", mask, 16'hFFFF);

      wclk(4);
      chk("R2 one strobe per frame", n_pulse, n_frames);
      chk("R2 queue drained", exp_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule